// File: doc/BRIEF.md
# Credit-Gated Packet Transmit Admission

This block stands between a queue of outgoing transaction packets and the transmitter that puts them on the link. The far receiver owns six separate buffers, a header store and a payload store for each of three traffic classes (posted writes, non-posted requests and completions). This block keeps one credit counter per buffer and lets a requested packet go only when its class has both a header credit and enough payload credits. The payload and header checks are independent, and both must pass in the same cycle.

At reset each counter loads the amount the receiver advertised. A grant takes the packet's credits from the two counters of its class. Credit returns from the far side are added back, in the same cycle as a deduction when both happen. No counter ever rises above the amount first advertised. A counter that was advertised as zero stands for an unlimited buffer: it never blocks a grant and always reads zero.

The requester presents a class, a payload length in dwords and a request strobe. It holds them until a grant arrives. Each cycle in which the strobe is high is one request, and grant answers it combinationally in that same cycle.

Top module: `fc_tx_gate`

## Requirements
- R1: While reset is low, and in the first cycle after it, every counter output equals the amount advertised for it (class index 0 = posted, 1 = non-posted, 2 = completion).
- R2: A packet whose class has a finite header counter at zero is not granted. A granted packet consumes exactly one header credit of its class.
- R3: A packet of L dwords needs ceil(L/4) payload credits. It is not granted unless its class's finite payload counter holds at least that many, and a grant consumes exactly that many.
- R4: A packet with a length of zero needs and consumes no payload credit, only one header credit.
- R5: Grant requires header and payload sufficiency at once. Either one alone failing blocks the packet.
- R6: Credits are deducted at the clock edge that ends the grant cycle and show on the counter outputs in the next cycle. Counters of other classes are not changed.
- R7: A credit return adds its amount to the matching counter. A return and a deduction on the same counter in the same cycle both take effect.
- R8: No finite counter exceeds its advertised amount. A return that would pass it leaves the counter at the advertised amount.
- R9: A counter advertised as zero never blocks a grant and stays at zero through grants and returns.
- R10: Grant is high only in a cycle where the request strobe is high and the class code is 0, 1 or 2. Class code 3 is never granted.
- R11: A request that is not granted changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; counters load advertised amounts |
| adv_hdr_i | input | 3 x HDR_W | Advertised header credits per class, sampled in reset |
| adv_dat_i | input | 3 x DATA_W | Advertised payload credits per class, sampled in reset |
| req_i | input | 1 | Request strobe, one packet per high cycle |
| req_class_i | input | 2 | Traffic class: 0 posted, 1 non-posted, 2 completion |
| req_len_i | input | LEN_W | Payload length in dwords |
| ret_hdr_i | input | 3 x HDR_W | Header credits returned this cycle per class |
| ret_dat_i | input | 3 x DATA_W | Payload credits returned this cycle per class |
| grant_o | output | 1 | Packet may be sent this cycle |
| lvl_hdr_o | output | 3 x HDR_W | Current header credit level per class |
| lvl_dat_o | output | 3 x DATA_W | Current payload credit level per class |

## Verification
The bench goes after the lengths that sit on a four-dword boundary and just past it (4, 5, 64, 65). A wrong rounding there would either grant a packet that overflows the receiver's store or starve one that fits. It drains the header counter and the payload counter separately, so that a design checking only one of the two would be caught granting. It also applies a return in the same cycle as a deduction, where a design that lets one update win would leave the level off by the dropped amount. Further tests push returns past the advertised amount to catch a missing saturation, and drive zero-advertised classes and the unused class code, where a faulty design would block forever or grant an undefined class.

// File: rtl/fc_gate_pkg.sv
// Shared class encoding for the credit gate.
// Assumes exactly three traffic classes; code 3 is unused.
package fc_gate_pkg;
    localparam int NUM_CLASS = 3;

    typedef enum logic [1:0] {
        CLS_POSTED    = 2'd0,
        CLS_NONPOSTED = 2'd1,
        CLS_COMPL     = 2'd2,
        CLS_UNUSED    = 2'd3
    } tlp_class_e;
endpackage

// File: rtl/fc_req_decode.sv
// Turns a request into per-class select lines and a payload credit need.
// Assumes length is in dwords and one payload credit covers four dwords.
module fc_req_decode #(
    parameter int LEN_W  = 11,
    parameter int DATA_W = 12
) (
    input  logic [1:0]        class_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [2:0]        sel_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] need_o
);
    import fc_gate_pkg::*;

    localparam int NEED_W = LEN_W - 1;

    logic [LEN_W:0] len_rnd;

    // Class code to one-hot select; the unused code selects nothing.
    always_comb begin
        sel_o = 3'b000;
        unique case (tlp_class_e'(class_i))
            CLS_POSTED:    sel_o = 3'b001;
            CLS_NONPOSTED: sel_o = 3'b010;
            CLS_COMPL:     sel_o = 3'b100;
            default:       sel_o = 3'b000;
        endcase
        valid_o = (sel_o != 3'b000);
    end

    // Round the dword count up to whole payload credits.
    always_comb begin
        len_rnd = {1'b0, len_i} + (LEN_W+1)'(3);
        need_o  = DATA_W'(len_rnd[LEN_W:2]);
    end

    initial begin
        assert (DATA_W > NEED_W)
            else $error("payload counter too narrow for longest packet");
    end
endmodule

// File: rtl/fc_credit_counter.sv
// One credit counter for one receiver buffer.
// Loads the advertised amount in reset and keeps it as the ceiling.
// An advertised zero means unlimited: the counter reads zero and always passes.
// Assumes take_i is only raised when ok_o is high.
module fc_credit_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] adv_i,
    input  logic         take_i,
    input  logic [W-1:0] amt_i,
    input  logic [W-1:0] ret_i,
    output logic [W-1:0] level_o,
    output logic         ok_o
);
    logic [W-1:0] limit_q;
    logic         unlimited;
    logic [W:0]   sum;
    logic [W-1:0] level_d;

    assign unlimited = (limit_q == '0);

    // Sufficiency of the current level for the requested amount.
    always_comb ok_o = unlimited || (level_o >= amt_i);

    // Next level: add return, subtract consumption, clamp at the ceiling.
    always_comb begin
        sum = {1'b0, level_o} + {1'b0, ret_i} - (take_i ? {1'b0, amt_i} : '0);
        if (unlimited)
            level_d = '0;
        else if (sum > {1'b0, limit_q})
            level_d = limit_q;
        else
            level_d = sum[W-1:0];
    end

    // Ceiling capture and level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= adv_i;
            level_o <= adv_i;
        end else begin
            level_o <= level_d;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= limit_q);
    p_take_covered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !unlimited |-> level_o >= amt_i);
    p_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && ret_i == '0 && !unlimited |=> level_o == $past(level_o) - $past(amt_i));
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i && ret_i == '0 |=> $stable(level_o));
    p_unlimited_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unlimited |-> level_o == '0);
endmodule

// File: rtl/fc_tx_gate.sv
// Credit gate in front of a packet transmitter.
// Keeps a header and a payload credit counter for each of three classes.
// Grants a request when its class has a header credit and enough payload
// credits, and deducts them at the edge that ends the grant cycle.
// Assumes the requester holds class and length until granted.
module fc_tx_gate #(
    parameter int HDR_W  = 8,
    parameter int DATA_W = 12,
    parameter int LEN_W  = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0][HDR_W-1:0]  adv_hdr_i,
    input  logic [2:0][DATA_W-1:0] adv_dat_i,
    input  logic                   req_i,
    input  logic [1:0]             req_class_i,
    input  logic [LEN_W-1:0]       req_len_i,
    input  logic [2:0][HDR_W-1:0]  ret_hdr_i,
    input  logic [2:0][DATA_W-1:0] ret_dat_i,
    output logic                   grant_o,
    output logic [2:0][HDR_W-1:0]  lvl_hdr_o,
    output logic [2:0][DATA_W-1:0] lvl_dat_o
);
    import fc_gate_pkg::*;

    logic [2:0]        sel;
    logic              cls_valid;
    logic [DATA_W-1:0] dat_need;
    logic [2:0]        hdr_ok;
    logic [2:0]        dat_ok;
    logic [2:0]        take;
    logic              both_ok;

    fc_req_decode #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_dec (
        .class_i (req_class_i),
        .len_i   (req_len_i),
        .sel_o   (sel),
        .valid_o (cls_valid),
        .need_o  (dat_need)
    );

    // Pick the selected class's header and payload sufficiency together.
    always_comb begin
        both_ok = 1'b0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (sel[c]) both_ok = hdr_ok[c] && dat_ok[c];
        end
        grant_o = req_i && cls_valid && both_ok;
        take    = grant_o ? sel : 3'b000;
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        fc_credit_counter #(.W(HDR_W)) u_hdr (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv_i   (adv_hdr_i[c]),
            .take_i  (take[c]),
            .amt_i   (HDR_W'(1)),
            .ret_i   (ret_hdr_i[c]),
            .level_o (lvl_hdr_o[c]),
            .ok_o    (hdr_ok[c])
        );
        fc_credit_counter #(.W(DATA_W)) u_dat (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv_i   (adv_dat_i[c]),
            .take_i  (take[c]),
            .amt_i   (dat_need),
            .ret_i   (ret_dat_i[c]),
            .level_o (lvl_dat_o[c]),
            .ok_o    (dat_ok[c])
        );
    end

    p_grant_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> req_i && req_class_i != 2'd3);
    p_single_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
endmodule

// File: tb/fc_tx_gate_test.sv
module fc_tx_gate_test;
    localparam int HDR_W  = 8;
    localparam int DATA_W = 12;
    localparam int LEN_W  = 11;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [2:0][HDR_W-1:0]  adv_hdr;
    logic [2:0][DATA_W-1:0] adv_dat;
    logic                   req = 1'b0;
    logic [1:0]             req_class = 2'd0;
    logic [LEN_W-1:0]       req_len = '0;
    logic [2:0][HDR_W-1:0]  ret_hdr = '0;
    logic [2:0][DATA_W-1:0] ret_dat = '0;
    logic                   grant;
    logic [2:0][HDR_W-1:0]  lvl_hdr;
    logic [2:0][DATA_W-1:0] lvl_dat;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fc_tx_gate #(.HDR_W(HDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .adv_hdr_i(adv_hdr), .adv_dat_i(adv_dat),
        .req_i(req), .req_class_i(req_class), .req_len_i(req_len),
        .ret_hdr_i(ret_hdr), .ret_dat_i(ret_dat), .grant_o(grant),
        .lvl_hdr_o(lvl_hdr), .lvl_dat_o(lvl_dat)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_levels(input string tag, input int h0, input int h1, input int h2,
                              input int d0, input int d1, input int d2);
        chk({tag, " hdr posted"}, lvl_hdr[0], h0);
        chk({tag, " hdr nonposted"}, lvl_hdr[1], h1);
        chk({tag, " hdr compl"}, lvl_hdr[2], h2);
        chk({tag, " dat posted"}, lvl_dat[0], d0);
        chk({tag, " dat nonposted"}, lvl_dat[1], d1);
        chk({tag, " dat compl"}, lvl_dat[2], d2);
    endtask

    // One cycle: drive at negedge, sample grant before posedge, clear at next negedge.
    task automatic cycle(input logic r, input int cls, input int len,
                         input int rh_cls, input int rh, input int rd_cls, input int rd,
                         input bit exp_g, input string tag);
        req = r;
        req_class = 2'(cls);
        req_len = LEN_W'(len);
        ret_hdr = '0;
        ret_dat = '0;
        if (rh_cls >= 0) ret_hdr[rh_cls] = HDR_W'(rh);
        if (rd_cls >= 0) ret_dat[rd_cls] = DATA_W'(rd);
        #5;
        chk({tag, " grant"}, int'(grant), int'(exp_g));
        @(negedge clk);
        req = 1'b0;
        ret_hdr = '0;
        ret_dat = '0;
    endtask

    task automatic t_reset();
        // R1: advertised amounts visible after reset, no grant without request
        chk_levels("R1 reset", 4, 2, 0, 16, 0, 32);
        #5 chk("R10 idle grant", int'(grant), 0);
        @(negedge clk);
    endtask

    task automatic t_round_up();
        // R3/R6: 5 dwords need 2 credits; only posted counters move
        cycle(1, 0, 5, -1, 0, -1, 0, 1, "R3 len5");
        chk_levels("R6 after len5", 3, 2, 0, 14, 0, 32);
        // R4: zero length takes header only
        cycle(1, 0, 0, -1, 0, -1, 0, 1, "R4 len0");
        chk_levels("R4 after len0", 2, 2, 0, 14, 0, 32);
        // R3: exact multiple of four needs one credit
        cycle(1, 0, 4, -1, 0, -1, 0, 1, "R3 len4");
        chk_levels("R3 after len4", 1, 2, 0, 13, 0, 32);
    endtask

    task automatic t_hdr_block();
        cycle(1, 0, 4, -1, 0, -1, 0, 1, "R2 last hdr");
        chk_levels("R2 hdr drained", 0, 2, 0, 12, 0, 32);
        // R2/R5: payload ample, header empty: blocked, nothing moves (R11)
        cycle(1, 0, 0, -1, 0, -1, 0, 0, "R5 no hdr");
        chk_levels("R11 blocked", 0, 2, 0, 12, 0, 32);
    endtask

    task automatic t_return();
        cycle(0, 0, 0, 0, 1, -1, 0, 0, "R7 hdr return");
        chk("R7 hdr return level", lvl_hdr[0], 1);
        // R7: return and deduction in the same cycle on the payload counter
        cycle(1, 0, 8, -1, 0, 0, 3, 1, "R7 concurrent");
        chk("R7 concurrent hdr", lvl_hdr[0], 0);
        chk("R7 concurrent dat", lvl_dat[0], 13);
        // R8: returns past the ceiling clamp
        cycle(0, 0, 0, 0, 9, 0, 10, 0, "R8 overfill");
        chk("R8 hdr clamp", lvl_hdr[0], 4);
        chk("R8 dat clamp", lvl_dat[0], 16);
    endtask

    task automatic t_dat_block();
        // R5: 65 dwords need 17 credits, 16 held: blocked despite header
        cycle(1, 0, 65, -1, 0, -1, 0, 0, "R5 no payload");
        chk_levels("R11 payload blocked", 4, 2, 0, 16, 0, 32);
        cycle(1, 0, 64, -1, 0, -1, 0, 1, "R3 len64");
        chk_levels("R3 after len64", 3, 2, 0, 0, 0, 32);
    endtask

    task automatic t_unlimited();
        // R9: non-posted payload advertised zero: large packets pass
        cycle(1, 1, 1000, -1, 0, -1, 0, 1, "R9 np1");
        cycle(1, 1, 1000, -1, 0, -1, 0, 1, "R9 np2");
        chk_levels("R9 np drained", 3, 0, 0, 0, 0, 32);
        cycle(1, 1, 0, -1, 0, -1, 0, 0, "R2 np no hdr");
        // R9: completion header advertised zero; payload finite
        cycle(1, 2, 128, -1, 0, -1, 0, 1, "R9 cpl");
        chk_levels("R9 cpl", 3, 0, 0, 0, 0, 0);
        cycle(1, 2, 1, -1, 0, -1, 0, 0, "R3 cpl no payload");
        cycle(0, 2, 0, 2, 5, 1, 7, 0, "R9 return ignored");
        chk("R9 cpl hdr stays zero", lvl_hdr[2], 0);
        chk("R9 np dat stays zero", lvl_dat[1], 0);
    endtask

    task automatic t_bad_class();
        // R10: class code 3 never granted, nothing moves
        cycle(1, 3, 0, -1, 0, -1, 0, 0, "R10 class3");
        chk_levels("R10 class3", 3, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, -1, 0, -1, 0, 0, "R10 no strobe");
        chk("R10 no strobe level", lvl_hdr[0], 3);
    endtask

    initial begin
        adv_hdr = '0;
        adv_dat = '0;
        adv_hdr[0] = 4; adv_dat[0] = 16;
        adv_hdr[1] = 2; adv_dat[1] = 0;
        adv_hdr[2] = 0; adv_dat[2] = 32;
        repeat (3) @(negedge clk);
        chk_levels("R1 in reset", 4, 2, 0, 16, 0, 32);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round_up();
        t_hdr_block();
        t_return();
        t_dat_block();
        t_unlimited();
        t_bad_class();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule